// File: doc/BRIEF.md
# Tape Transport Safety Supervisor

This block guards a cassette transport against two faults: a tape that has stopped moving while the drive believes it is running, and a cassette pulled out of the deck. It watches four asynchronous inputs: a free-running reference oscillator of nominally 1050 Hz (±5 %), the pulse train from a magnetic pickup on the take-up reel, a light-barrier level that is low when no cassette is present, and a record-safety tab sensor that is high when the tab has been broken out. From these it raises a stop request, cancels recording, drives the stop lamp, and gates record key presses.

The tape-motion window is measured in reference-oscillator periods rather than in system clock cycles. As a result, the length of the window tracks the oscillator that the service adjustment trims, and it does not depend on the system clock frequency. The window only runs while the transport is moving (play, record, fast forward, rewind). If the cassette is taken out, the deck stops and the stop lamp flashes until the next accepted key command. If the deck was playing at that moment, the play state is kept for the transport controller to resume from.

The transport state machine sits outside this block. It supplies the current mode and a strobe for every accepted key command, and it acts on the stop and cancel outputs.

Top module: `tts_supervisor`

## Requirements
- R1: While reset is asserted, stop_req, rec_cancel, stop_led, rec_inhibit, rec_go and play_mem are all low.
- R2: The mode input is encoded as 0 stop, 1 play, 2 record, 3 fast forward, 4 rewind, 5 pause. In modes 1 to 4, stop_req rises after TIMEOUT_REFS rising edges of ref_osc_in with no rising edge of motion_in in between. It stays low after TIMEOUT_REFS-1 such edges.
- R3: Every rising edge of motion_in restarts the reference-edge count from zero.
- R4: The motion timeout never fires in stop (0) or pause (5). A latched motion fault clears within three clocks of mode becoming 0 or 5.
- R5: While cassette_in is low (cassette removed), stop_req is high. Both inputs pass through a two-stage synchronizer.
- R6: rec_cancel is high exactly while the cassette is removed and the mode is record (2).
- R7: When the cassette is removed while the mode is play (1), play_mem goes high and stays high after the cassette is reinserted. It stays high until key_valid is pulsed. Removal in any other mode leaves play_mem low.
- R8: Each present-to-removed transition of the cassette starts flashing. While flashing, stop_led toggles every BLINK_HALF clock cycles, whether or not the cassette is reinserted. A key_valid pulse ends the flashing. When not flashing, stop_led is high exactly when the mode is stop (0).
- R9: rec_inhibit follows the synchronized rec_tab_in level. A rec_key pulse produces a one-cycle rec_go in the next cycle only when rec_tab_in is low. While rec_tab_in is high, rec_key is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Current transport mode (0 stop, 1 play, 2 record, 3 FF, 4 rewind, 5 pause) |
| key_valid | input | 1 | One-cycle strobe for each accepted key command |
| rec_key | input | 1 | One-cycle strobe for a record button press |
| ref_osc_in | input | 1 | Asynchronous reference oscillator, about 1050 Hz |
| motion_in | input | 1 | Asynchronous take-up reel motion pulses |
| cassette_in | input | 1 | Asynchronous light-barrier level, low = cassette removed |
| rec_tab_in | input | 1 | Asynchronous record-safety level, high = tab missing |
| stop_req | output | 1 | Request to stop the transport |
| rec_cancel | output | 1 | Request to abandon recording |
| stop_led | output | 1 | Stop lamp drive, steady or flashing |
| rec_inhibit | output | 1 | Record presses are being refused |
| rec_go | output | 1 | One-cycle strobe for an accepted record press |
| play_mem | output | 1 | Play state remembered across a cassette removal |

## Verification
An off-by-one in the reference-edge counter shows at stop_req one reference period early or late, so the bench brackets the limit from both sides in every mode. A motion restart that fails to clear the count shows up as a premature stop within one window. A wrong removal latch shows within three clocks on rec_cancel or play_mem, or as a stop lamp that keeps flashing after a key command. A blink counter with the wrong wrap value shows as lamp runs whose length differs from BLINK_HALF, and every complete run is measured.

// File: rtl/tts_pkg.sv
package tts_pkg;

    typedef enum logic [2:0] {
        MODE_STOP  = 3'd0,
        MODE_PLAY  = 3'd1,
        MODE_REC   = 3'd2,
        MODE_FF    = 3'd3,
        MODE_REW   = 3'd4,
        MODE_PAUSE = 3'd5
    } tape_mode_e;

    typedef struct packed {
        logic removed;
        logic stop_req;
        logic rec_cancel;
        logic stop_led;
        logic rec_inhibit;
        logic rec_go;
        logic play_mem;
    } sup_state_t;

    localparam int LANES     = 4;
    localparam int LANE_REF  = 0;
    localparam int LANE_MOT  = 1;
    localparam int LANE_CAS  = 2;
    localparam int LANE_TAB  = 3;

endpackage

// File: rtl/tts_sync.sv
module tts_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    // [0] first stage, [1] second stage, [2] previous second-stage value
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1], sh_q[0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {3{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign level = sh_q[1];
    assign rise  = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/tts_motion_watch.sv
module tts_motion_watch #(
    parameter int TIMEOUT_REFS = 1050
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ref_rise,
    input  logic motion_rise,
    output logic fault
);
    localparam int CW = (TIMEOUT_REFS > 2) ? $clog2(TIMEOUT_REFS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_REFS - 1);

    typedef struct packed {
        logic          fault;
        logic [CW-1:0] cnt;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (!active) begin
            w_d.cnt   = '0;
            w_d.fault = 1'b0;
        end else if (motion_rise) begin
            w_d.cnt = '0;
        end else if (ref_rise && !w_q.fault) begin
            if (w_q.cnt == LAST) begin
                w_d.fault = 1'b1;
                w_d.cnt   = '0;
            end else begin
                w_d.cnt = w_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign fault = w_q.fault;
endmodule

// File: rtl/tts_blink.sv
module tts_blink #(
    parameter int BLINK_HALF = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    output logic on,
    output logic phase
);
    localparam int CW = (BLINK_HALF > 2) ? $clog2(BLINK_HALF) : 1;
    localparam logic [CW-1:0] WRAP = CW'(BLINK_HALF - 1);

    typedef struct packed {
        logic          on;
        logic          phase;
        logic [CW-1:0] cnt;
    } blink_t;

    blink_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (start) begin
            b_d.on    = 1'b1;
            b_d.phase = 1'b1;
            b_d.cnt   = '0;
        end else if (clear) begin
            b_d.on    = 1'b0;
            b_d.phase = 1'b0;
            b_d.cnt   = '0;
        end else if (b_q.on) begin
            if (b_q.cnt == WRAP) begin
                b_d.cnt   = '0;
                b_d.phase = ~b_q.phase;
            end else begin
                b_d.cnt = b_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign on    = b_q.on;
    assign phase = b_q.phase;
endmodule

// File: rtl/tts_supervisor.sv
module tts_supervisor
    import tts_pkg::*;
#(
    parameter int TIMEOUT_REFS = 1050,
    parameter int BLINK_HALF   = 12_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       key_valid,
    input  logic       rec_key,
    input  logic       ref_osc_in,
    input  logic       motion_in,
    input  logic       cassette_in,
    input  logic       rec_tab_in,
    output logic       stop_req,
    output logic       rec_cancel,
    output logic       stop_led,
    output logic       rec_inhibit,
    output logic       rec_go,
    output logic       play_mem
);
    // cassette lane resets to "present" so reset never looks like a removal
    localparam logic [LANES-1:0] RST_LVL = LANES'(1) << LANE_CAS;

    logic [LANES-1:0] raw_in, lvl, rise;
    assign raw_in = {rec_tab_in, cassette_in, motion_in, ref_osc_in};

    for (genvar g = 0; g < LANES; g++) begin : g_sync
        tts_sync #(.RST_VAL(RST_LVL[g])) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[g]),
            .level (lvl[g]),
            .rise  (rise[g])
        );
    end

    logic unused_rise;
    assign unused_rise = ^{rise[LANE_CAS], rise[LANE_TAB], lvl[LANE_REF], lvl[LANE_MOT]};

    tape_mode_e m;
    assign m = tape_mode_e'(mode);

    logic moving;
    assign moving = (m == MODE_PLAY) || (m == MODE_REC) ||
                    (m == MODE_FF)   || (m == MODE_REW);

    logic motion_fault;
    tts_motion_watch #(.TIMEOUT_REFS(TIMEOUT_REFS)) u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (moving),
        .ref_rise    (rise[LANE_REF]),
        .motion_rise (rise[LANE_MOT]),
        .fault       (motion_fault)
    );

    sup_state_t st_d, st_q;
    logic removed_now, removal_evt;
    assign removed_now = ~lvl[LANE_CAS];
    assign removal_evt = removed_now & ~st_q.removed;

    logic flash_on, flash_phase;
    tts_blink #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .start (removal_evt),
        .clear (key_valid),
        .on    (flash_on),
        .phase (flash_phase)
    );

    always_comb begin
        st_d             = st_q;
        st_d.removed     = removed_now;
        st_d.stop_req    = removed_now | motion_fault;
        st_d.rec_cancel  = removed_now & (m == MODE_REC);
        st_d.rec_inhibit = lvl[LANE_TAB];
        st_d.rec_go      = rec_key & ~lvl[LANE_TAB];
        st_d.stop_led    = flash_on ? flash_phase : (m == MODE_STOP);
        if (removal_evt && (m == MODE_PLAY)) st_d.play_mem = 1'b1;
        else if (key_valid)                  st_d.play_mem = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stop_req    = st_q.stop_req;
    assign rec_cancel  = st_q.rec_cancel;
    assign stop_led    = st_q.stop_led;
    assign rec_inhibit = st_q.rec_inhibit;
    assign rec_go      = st_q.rec_go;
    assign play_mem    = st_q.play_mem;
endmodule

// File: rtl/tts_checker.sv
module tts_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       key_valid,
    input logic       removal_evt,
    input logic       motion_fault,
    input logic       stop_req,
    input logic       rec_cancel,
    input logic       rec_inhibit,
    input logic       rec_go,
    input logic       play_mem
);
    assert_tab_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_go && rec_inhibit));

    assert_cancel_in_rec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_cancel |-> ($past(mode) == 3'd2));

    assert_cancel_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_cancel |-> stop_req);

    assert_fault_while_moving_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(motion_fault) |-> ($past(mode) != 3'd0 && $past(mode) != 3'd5));

    assert_fault_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        motion_fault |=> stop_req);

    assert_key_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && !removal_evt) |=> !play_mem);
endmodule

bind tts_supervisor tts_checker i_tts_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .key_valid    (key_valid),
    .removal_evt  (removal_evt),
    .motion_fault (motion_fault),
    .stop_req     (stop_req),
    .rec_cancel   (rec_cancel),
    .rec_inhibit  (rec_inhibit),
    .rec_go       (rec_go),
    .play_mem     (play_mem)
);

// File: tb/test_tts_supervisor.sv
`timescale 1ns/1ps
module test_tts_supervisor;
    localparam int T    = 4;
    localparam int HALF = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       key_valid = 1'b0, rec_key = 1'b0;
    logic       ref_osc_in = 1'b0, motion_in = 1'b0;
    logic       cassette_in = 1'b1, rec_tab_in = 1'b0;
    logic       stop_req, rec_cancel, stop_led, rec_inhibit, rec_go, play_mem;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tts_supervisor #(.TIMEOUT_REFS(T), .BLINK_HALF(HALF)) i_tts_supervisor (
        .clk(clk), .rst_n(rst_n), .mode(mode), .key_valid(key_valid),
        .rec_key(rec_key), .ref_osc_in(ref_osc_in), .motion_in(motion_in),
        .cassette_in(cassette_in), .rec_tab_in(rec_tab_in),
        .stop_req(stop_req), .rec_cancel(rec_cancel), .stop_led(stop_led),
        .rec_inhibit(rec_inhibit), .rec_go(rec_go), .play_mem(play_mem)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ref_pulse();
        ref_osc_in = 1'b1; wait_n(3);
        ref_osc_in = 1'b0; wait_n(3);
    endtask

    task automatic motion_pulse();
        motion_in = 1'b1; wait_n(3);
        motion_in = 1'b0; wait_n(3);
    endtask

    task automatic key_pulse();
        key_valid = 1'b1; wait_n(1);
        key_valid = 1'b0; wait_n(2);
    endtask

    function automatic int is_moving(input int md);
        return (md >= 1 && md <= 4) ? 1 : 0;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        wait_n(3);
        chk("R1 stop_req", stop_req, 0);
        chk("R1 rec_cancel", rec_cancel, 0);
        chk("R1 stop_led", stop_led, 0);
        chk("R1 rec_inhibit", rec_inhibit, 0);
        chk("R1 rec_go", rec_go, 0);
        chk("R1 play_mem", play_mem, 0);
        rst_n = 1'b1;
        wait_n(4);
        chk("R8 steady lamp in stop", stop_led, 1);
        chk("R5 no stop with cassette", stop_req, 0);

        // R2/R4 timeout sweep over every mode
        for (int md = 0; md < 6; md++) begin
            mode = 3'(md);
            wait_n(3);
            for (int k = 0; k < T - 1; k++) ref_pulse();
            chk($sformatf("R2 no stop before limit mode %0d", md), stop_req, 0);
            ref_pulse();
            chk($sformatf("R2 R4 stop at limit mode %0d", md), stop_req, is_moving(md));
            mode = 3'd0;
            wait_n(3);
            chk($sformatf("R4 fault cleared after mode %0d", md), stop_req, 0);
        end

        // R3 restart on motion edges
        mode = 3'd3;
        wait_n(3);
        for (int rep = 0; rep < 3; rep++) begin
            for (int k = 0; k < T - 1; k++) ref_pulse();
            motion_pulse();
            chk("R3 window restarted", stop_req, 0);
        end
        for (int k = 0; k < T; k++) ref_pulse();
        chk("R3 stop after full window", stop_req, 1);
        mode = 3'd5;
        wait_n(3);
        chk("R4 pause clears fault", stop_req, 0);

        // R5/R6/R7 removal sweep over every mode
        for (int md = 0; md < 6; md++) begin
            mode = 3'(md);
            wait_n(3);
            cassette_in = 1'b0;
            wait_n(4);
            chk($sformatf("R5 stop on removal mode %0d", md), stop_req, 1);
            chk($sformatf("R6 cancel mode %0d", md), rec_cancel, (md == 2) ? 1 : 0);
            chk($sformatf("R7 play stored mode %0d", md), play_mem, (md == 1) ? 1 : 0);
            cassette_in = 1'b1;
            wait_n(4);
            chk($sformatf("R5 stop released mode %0d", md), stop_req, 0);
            chk($sformatf("R6 cancel released mode %0d", md), rec_cancel, 0);
            chk($sformatf("R7 play kept mode %0d", md), play_mem, (md == 1) ? 1 : 0);
            key_pulse();
            chk($sformatf("R7 key clears mode %0d", md), play_mem, 0);
            mode = 3'd0;
            wait_n(2);
        end

        // R8 flash timing
        mode = 3'd1;
        wait_n(2);
        cassette_in = 1'b0;
        wait_n(4);
        cassette_in = 1'b1;
        begin
            logic prev;
            int run;
            int toggles;
            prev = stop_led;
            run = 1;
            toggles = 0;
            for (int i = 0; i < 6 * HALF; i++) begin
                @(negedge clk);
                if (stop_led == prev) run++;
                else begin
                    if (toggles > 0) chk("R8 blink half period", run, HALF);
                    toggles++;
                    run = 1;
                    prev = stop_led;
                end
            end
            chk("R8 blink keeps toggling", (toggles >= 5) ? 1 : 0, 1);
        end
        key_pulse();
        begin
            int highs;
            highs = 0;
            for (int i = 0; i < 3 * HALF; i++) begin
                @(negedge clk);
                if (stop_led) highs++;
            end
            chk("R8 flash ends on key, lamp off in play", highs, 0);
        end
        mode = 3'd0;
        wait_n(2);
        chk("R8 lamp steady in stop", stop_led, 1);

        // R9 tab sweep
        for (int tab = 0; tab < 2; tab++) begin
            for (int key = 0; key < 2; key++) begin
                rec_tab_in = 1'(tab);
                wait_n(4);
                chk($sformatf("R9 inhibit tab %0d", tab), rec_inhibit, tab);
                rec_key = 1'(key);
                wait_n(1);
                rec_key = 1'b0;
                chk($sformatf("R9 rec_go tab %0d key %0d", tab, key), rec_go,
                    (key == 1 && tab == 0) ? 1 : 0);
                wait_n(1);
                chk("R9 rec_go one cycle", rec_go, 0);
            end
        end

        summary();
        $finish;
    end
endmodule